// File: doc/BRIEF.md
# Two-Lane Block FIR Filter

This block is an N-tap finite impulse response filter that consumes two consecutive input samples per clock and returns the two matching filtered outputs in the same clock. Doubling the samples per clock doubles the sample rate at a given clock frequency. Another way to use it is to halve the clock for the same sample rate, which saves power. Every output is the convolution y(n) = sum over i = 0..N-1 of h(i)·x(n−i).

A block of two samples arrives on two 8-bit lanes under one valid flag. The early lane carries x(2k) and the late lane carries x(2k+1). Coefficients are 8-bit two's complement and are fixed at elaboration through one packed parameter. The multiply and the summation sit in separate register stages, so no clock period holds a multiply followed by an adder chain.

Results leave at full precision, 16 bits plus ceil(log2 N) guard bits. They come with a valid flag that runs in step with the datapath registers. Only accepted blocks enter the sample history. Cycles with the input flag low leave the filter state untouched.

Top module: `fir2p_core`

## Requirements
- R1: When out_valid is high, y_even equals the sum over i of h(i)·x(2k−i), where x(2k) is the early-lane sample of the block that produced it and older samples come from earlier accepted blocks.
- R2: When out_valid is high, y_odd equals the sum over i of h(i)·x(2k+1−i) for the same block, so its newest tap uses the late-lane sample and its second tap uses the early-lane sample of the same block.
- R3: Results are two's complement, SW = 16 + ceil(log2 NTAPS) bits wide (19 for the default 5 taps), and are never truncated. Inputs at −128 and 127 yield sums beyond the 16-bit range that still appear exactly.
- R4: A block accepted at a rising edge with in_valid high appears with out_valid high after the second following rising edge. Each accepted block yields exactly one valid result, in order.
- R5: A cycle with in_valid low has no effect on the history. Its lane data are ignored and later results are as if that cycle never happened.
- R6: While out_valid is low, y_even and y_odd keep their previous values.
- R7: Reset is synchronous and active low. It clears the sample history and the valid pipeline, so on the first cycle after release out_valid is 0, both results are 0 and samples before reset count as zero.
- R8: Tap i takes the signed 8-bit coefficient at bits [8i+7:8i] of parameter COEFS, so tap 0 multiplies the newest sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Both sample lanes hold a block to accept |
| x_even | input | 8 | Earlier sample of the block, x(2k), two's complement |
| x_odd | input | 8 | Later sample of the block, x(2k+1), two's complement |
| out_valid | output | 1 | Both result lanes hold a new block of outputs |
| y_even | output | SW | Filter output for x(2k), two's complement |
| y_odd | output | SW | Filter output for x(2k+1), two's complement |

## Verification
The hardest case to reach from the ports is a result whose taps straddle a gap in accepted blocks, or a reset that lands while blocks are still in the pipeline. Only a wrong history update or a stale pipeline stage would corrupt such a result. The stimulus mixes idle cycles carrying random lane data between accepted blocks, and fires a reset with three blocks in flight. Unit impulses on each lane expose the tap order of both lanes, and an alternating 127/−128 stream pushes the sums past 16 bits.

// File: rtl/fir2p_pkg.sv
// Package fir2p_pkg
// Shared sample and product types for the two-lane FIR datapath.
// Assumes 8-bit two's complement samples and coefficients.
package fir2p_pkg;

    localparam int SAMPLE_W = 8;
    localparam int PROD_W   = 2 * SAMPLE_W;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [PROD_W-1:0]   prod_t;

    // Accumulator width: full product plus guard bits for ntaps terms.
    function automatic int acc_width(input int ntaps);
        return PROD_W + $clog2(ntaps);
    endfunction

endpackage

// File: rtl/fir2p_tapline.sv
// Module fir2p_tapline
// Holds the sample history and registers the tap window for one block.
// win_q[j] holds x(2k+1-j), j = 0..NTAPS, for the block accepted most recently.
// The history only shifts (by two) when a block is accepted.
// Assumes NTAPS >= 2.
module fir2p_tapline
    import fir2p_pkg::*;
#(
    parameter int NTAPS = 5
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    in_valid,
    input  sample_t x_even,
    input  sample_t x_odd,
    output sample_t win_q [NTAPS+1]
);

    localparam int HIST = NTAPS - 1;

    sample_t hist_q [HIST];

    // History: hist_q[m] = x(2k+1-m) after the block holding x(2k+1) is taken.
    for (genvar m = 0; m < HIST; m++) begin : g_hist
        if (m == 0) begin : g_late
            // Newest entry takes the late-lane sample.
            always_ff @(posedge clk) begin
                if (!rst_n)        hist_q[m] <= '0;
                else if (in_valid) hist_q[m] <= x_odd;
            end
        end else if (m == 1) begin : g_early
            // Second entry takes the early-lane sample.
            always_ff @(posedge clk) begin
                if (!rst_n)        hist_q[m] <= '0;
                else if (in_valid) hist_q[m] <= x_even;
            end
        end else begin : g_shift
            // Older entries move two places per block.
            always_ff @(posedge clk) begin
                if (!rst_n)        hist_q[m] <= '0;
                else if (in_valid) hist_q[m] <= hist_q[m-2];
            end
        end
    end

    // Window: fresh block samples plus the history as it was before the block.
    for (genvar j = 0; j <= NTAPS; j++) begin : g_win
        if (j == 0) begin : g_w0
            // Window slot for x(2k+1).
            always_ff @(posedge clk) begin
                if (!rst_n)        win_q[j] <= '0;
                else if (in_valid) win_q[j] <= x_odd;
            end
        end else if (j == 1) begin : g_w1
            // Window slot for x(2k).
            always_ff @(posedge clk) begin
                if (!rst_n)        win_q[j] <= '0;
                else if (in_valid) win_q[j] <= x_even;
            end
        end else begin : g_wh
            // Window slot for x(2k+1-j) taken from history.
            always_ff @(posedge clk) begin
                if (!rst_n)        win_q[j] <= '0;
                else if (in_valid) win_q[j] <= hist_q[j-2];
            end
        end
    end

endmodule

// File: rtl/fir2p_mac_lane.sv
// Module fir2p_mac_lane
// One output lane: a registered multiply stage followed by a registered sum.
// taps[i] is the sample that multiplies coefficient i.
// Assumes enables come from the matching valid pipeline stages.
module fir2p_mac_lane
    import fir2p_pkg::*;
#(
    parameter int                        NTAPS = 5,
    parameter logic [NTAPS*SAMPLE_W-1:0] COEFS = '0,
    parameter int                        SW    = acc_width(NTAPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 prod_en,
    input  logic                 sum_en,
    input  sample_t              taps [NTAPS],
    output logic signed [SW-1:0] y_q
);

    prod_t                prod_q [NTAPS];
    logic signed [SW-1:0] acc;

    for (genvar i = 0; i < NTAPS; i++) begin : g_mul
        localparam sample_t CI = sample_t'(COEFS[i*SAMPLE_W +: SAMPLE_W]);
        // Register one exact 16-bit product per tap.
        always_ff @(posedge clk) begin
            if (!rst_n)       prod_q[i] <= '0;
            else if (prod_en) prod_q[i] <= prod_t'(taps[i]) * prod_t'(CI);
        end
    end

    // Sign-extend and add every product at full width.
    always_comb begin
        acc = '0;
        for (int i = 0; i < NTAPS; i++) begin
            acc = acc + SW'(prod_q[i]);
        end
    end

    // Capture the sum; hold it while no result is due.
    always_ff @(posedge clk) begin
        if (!rst_n)      y_q <= '0;
        else if (sum_en) y_q <= acc;
    end

endmodule

// File: rtl/fir2p_core.sv
// Module fir2p_core
// Two-samples-per-clock FIR filter: a shared tap window feeds two MAC lanes.
// Three register stages: window, products, sums; out_valid follows them.
// Assumes NTAPS >= 2 and coefficients fixed at elaboration.
module fir2p_core
    import fir2p_pkg::*;
#(
    parameter int                        NTAPS = 5,
    parameter logic [NTAPS*SAMPLE_W-1:0] COEFS = {8'h7F, 8'h80, 8'h07, 8'hFB, 8'h03},
    localparam int                       SW    = acc_width(NTAPS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] x_even,
    input  logic [SAMPLE_W-1:0] x_odd,
    output logic                out_valid,
    output logic [SW-1:0]       y_even,
    output logic [SW-1:0]       y_odd
);

    localparam int STAGES = 3;

    sample_t                win_q [NTAPS+1];
    logic [STAGES-1:0]      vld_q;
    logic signed [SW-1:0]   y_lane [2];

    fir2p_tapline #(.NTAPS(NTAPS)) u_tapline (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .x_even   (sample_t'(x_even)),
        .x_odd    (sample_t'(x_odd)),
        .win_q    (win_q)
    );

    // Valid pipeline, one bit per datapath register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= {vld_q[STAGES-2:0], in_valid};
    end

    // Lane 0 starts at x(2k) (window slot 1), lane 1 at x(2k+1) (slot 0).
    for (genvar l = 0; l < 2; l++) begin : g_lane
        localparam int OFF = (l == 0) ? 1 : 0;
        sample_t taps [NTAPS];
        for (genvar i = 0; i < NTAPS; i++) begin : g_tap
            assign taps[i] = win_q[i + OFF];
        end
        fir2p_mac_lane #(.NTAPS(NTAPS), .COEFS(COEFS), .SW(SW)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .prod_en (vld_q[0]),
            .sum_en  (vld_q[1]),
            .taps    (taps),
            .y_q     (y_lane[l])
        );
    end

    assign y_even    = y_lane[0];
    assign y_odd     = y_lane[1];
    assign out_valid = vld_q[STAGES-1];

endmodule

// File: rtl/fir2p_core_chk.sv
// Module fir2p_core_chk
// Port-level protocol checks for fir2p_core, attached through bind.
// Assumes it sees the top module's ports unchanged.
module fir2p_core_chk #(
    parameter int NTAPS = 5,
    parameter int SW    = 19
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          out_valid,
    input logic [SW-1:0] y_even,
    input logic [SW-1:0] y_odd
);

    localparam longint BOUND = longint'(NTAPS) * 16384;

    logic [2:0] seen_q;
    logic       in_rst_q;

    // Count edges since reset release, saturating at 4.
    always_ff @(posedge clk) begin
        if (!rst_n)           seen_q <= '0;
        else if (seen_q != 4) seen_q <= seen_q + 3'd1;
    end

    // R7: the cycle after a reset edge shows an idle, cleared output.
    always_ff @(posedge clk) begin
        if (in_rst_q) begin
            a_reset_clear_r7: assert (!out_valid && y_even == '0 && y_odd == '0)
                else $error("reset did not clear outputs");
        end
        in_rst_q <= !rst_n;
    end

    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q >= 3) |-> (out_valid == $past(in_valid, 3)));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q >= 1 && !out_valid) |-> ($stable(y_even) && $stable(y_odd)));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (longint'($signed(y_even)) <= BOUND && longint'($signed(y_even)) >= -BOUND
                    && longint'($signed(y_odd))  <= BOUND && longint'($signed(y_odd))  >= -BOUND));

endmodule

bind fir2p_core fir2p_core_chk #(.NTAPS(NTAPS), .SW(SW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .y_even    (y_even),
    .y_odd     (y_odd)
);

// File: tb/fir2p_core_bench.sv
// Scoreboard bench: the driver computes expected outputs by direct convolution
// over the accepted-sample history and queues them; a monitor pops and compares.
module fir2p_core_bench;

    localparam int          NT    = 5;
    localparam logic [39:0] COEFS = {8'h7F, 8'h80, 8'h07, 8'hFB, 8'h03}; // R8: 3,-5,7,-128,127
    localparam int          SW    = 16 + $clog2(NT);

    typedef struct {
        longint ye;
        longint yo;
        int     tag;
    } exp_t;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          in_valid = 0;
    logic [7:0]    x_even = '0;
    logic [7:0]    x_odd = '0;
    logic          out_valid;
    logic [SW-1:0] y_even;
    logic [SW-1:0] y_odd;

    int     checks = 0;
    int     failures = 0;
    int     cyc = 0;
    int     xs[$];
    exp_t   q[$];
    string  phase = "init";
    bit     prev_rst = 0;
    logic [SW-1:0] prev_ye, prev_yo;

    fir2p_core #(.NTAPS(NT), .COEFS(COEFS)) u_fir2p_core (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .x_even(x_even), .x_odd(x_odd),
        .out_valid(out_valid), .y_even(y_even), .y_odd(y_odd)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int coef(input int i);
        logic signed [7:0] c;
        c = COEFS[i*8 +: 8];
        return int'(c);
    endfunction

    // Reference convolution; samples before the history start count as zero.
    function automatic longint ref_at(input int n);
        longint s = 0;
        for (int i = 0; i < NT; i++) begin
            if (n - i >= 0) s += longint'(coef(i)) * longint'(xs[n-i]);
        end
        return s;
    endfunction

    function automatic int rnd8();
        logic signed [7:0] b;
        b = 8'($urandom);
        return int'(b);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s [%s] actual=%0d expected=%0d t=%0t", req, phase, act, exp, $time);
        end
    endtask

    // Driver: one block per call, inputs change 2 ns after the edge.
    task automatic drive(input int e, input int o, input bit v);
        exp_t it;
        @(posedge clk);
        #2;
        in_valid = v;
        x_even   = 8'(e);
        x_odd    = 8'(o);
        if (v) begin
            xs.push_back(e);
            xs.push_back(o);
            it.ye  = ref_at(xs.size() - 2);
            it.yo  = ref_at(xs.size() - 1);
            it.tag = cyc + 1;
            q.push_back(it);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) drive(rnd8(), rnd8(), 0); // R5: junk data, flag low
    endtask

    task automatic do_reset(input int n);
        @(posedge clk);
        #2;
        rst_n = 0;
        in_valid = 0;
        xs.delete();
        q.delete();
        repeat (n) @(posedge clk);
        #2;
        rst_n = 1;
    endtask

    // Monitor: samples at the falling edge.
    always @(negedge clk) begin
        exp_t it;
        if (!rst_n) begin
            prev_rst = 0;
        end else begin
            if (!prev_rst) begin
                check(out_valid == 1'b0, "R7 out_valid after reset", longint'(out_valid), 0);
                check(y_even == '0 && y_odd == '0, "R7 results after reset",
                      longint'($signed(y_even)), 0);
            end else if (out_valid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R4 unexpected result", 1, 0);
                end else begin
                    it = q.pop_front();
                    check(cyc - it.tag == 2, "R4 latency", longint'(cyc - it.tag), 2);
                    check(longint'($signed(y_even)) == it.ye, "R1 even lane",
                          longint'($signed(y_even)), it.ye);
                    check(longint'($signed(y_odd)) == it.yo, "R2 odd lane",
                          longint'($signed(y_odd)), it.yo);
                end
            end else begin
                check(y_even == prev_ye && y_odd == prev_yo, "R6 hold while idle",
                      longint'($signed(y_even)), longint'($signed(prev_ye)));
            end
            prev_ye  = y_even;
            prev_yo  = y_odd;
            prev_rst = 1;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        phase = "reset";                      // R7
        do_reset(3);
        idle(2);

        phase = "impulse_even";               // R8, R1: tap order on the early lane
        drive(1, 0, 1);
        for (int k = 0; k < 3; k++) drive(0, 0, 1);
        phase = "impulse_odd";                // R8, R2: tap order on the late lane
        drive(0, 1, 1);
        for (int k = 0; k < 3; k++) drive(0, 0, 1);
        idle(4);

        phase = "gaps";                       // R5, R6: idle cycles between blocks
        for (int k = 0; k < 30; k++) begin
            drive(rnd8(), rnd8(), 1);
            if (k % 3 == 0) idle(1 + k % 4);
        end

        phase = "extreme";                    // R3: sums beyond 16 bits
        for (int k = 0; k < 8; k++) drive(127, -128, 1);
        for (int k = 0; k < 8; k++) drive(-128, 127, 1);
        for (int k = 0; k < 4; k++) drive(-128, -128, 1);
        idle(3);

        phase = "random";
        for (int k = 0; k < 200; k++) begin
            drive(rnd8(), rnd8(), 1);
            if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
        end

        phase = "mid_reset";                  // R7: reset with blocks in flight
        drive(100, -77, 1);
        drive(-5, 64, 1);
        drive(33, 12, 1);
        do_reset(2);
        drive(9, -9, 1);                      // history must read as zero
        for (int k = 0; k < 10; k++) drive(rnd8(), rnd8(), 1);
        idle(6);

        phase = "drain";
        check(q.size() == 0, "R4 all results emerged", longint'(q.size()), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule